// File: doc/BRIEF.md
# Program Interrupt Trap Unit

This block sits in front of instruction commit and decides, for each decoded instruction, whether the instruction may retire or must instead raise a program interrupt. It looks at the decoded operation class and the instruction word to judge whether the operation needs supervisor rights. It also reads the problem-state bit of the machine state register and a decoder flag that marks the instruction as illegal. A privileged operation attempted in problem state, or any illegal instruction, produces a trap.

On a trap the unit hands the commit stage everything the interrupt needs. This is the address of the trapping instruction for the first save/restore register, the unmodified machine state for the second, and a machine state value with the matching cause bit set. The next fetch address is redirected to the program-interrupt vector, and all of the instruction's own writebacks are blocked. Without a trap it passes on the sequential address or the branch target and lets the writebacks through. Results appear one clock after the instruction is presented.

Top module: `ptrap_unit`

## Requirements
- R1: Operation class codes 1 (attention), 2 (read machine state), 3 and 4 (the two forms of write machine state) and 5 (return from interrupt) are always privileged. Code 0 (ordinary operation) is never privileged.
- R2: Class codes 6 (read special register) and 7 (write special register) are privileged only when instruction bit 20 (LSB-numbered, the top bit of the special register number) is 1.
- R3: A privileged instruction traps only when `in_msr[14]` (problem state) is 1. With `in_msr[14]` at 0 it does not trap unless it is illegal.
- R4: On a trap, `out_srr0_we` and `out_srr1_we` are high, `out_srr0` equals the presented `in_cia`, and `out_srr1` equals the presented `in_msr` unchanged.
- R5: An illegal instruction always traps. On any trap `out_msr_we` is high and `out_msr` equals `in_msr` with the cause bit set: bit 18 for a privilege trap, bit 19 for an illegal trap. All other bits are unchanged. Without a trap `out_msr_we` is low.
- R6: When an instruction is both illegal and a privilege violation, the privilege cause (bit 18) is reported and bit 19 stays as presented.
- R7: On a trap `out_nia` is 0x700, whatever the branch inputs say.
- R8: Without a trap, `out_nia` is `in_br_target` when `in_br_taken` is 1, else `in_cia + 4` modulo 2^64.
- R9: `out_commit_wb` is high for an accepted instruction exactly when it does not trap, and is never high together with `out_trap`.
- R10: An instruction presented with `in_valid` high yields `out_valid` high on the next cycle. A cycle with `in_valid` low yields `out_valid`, `out_trap`, `out_commit_wb` and all write enables low on the next cycle.
- R11: After a synchronous reset (`rst_n` low at a clock edge), all output strobes are low and `out_nia`, `out_srr0`, `out_srr1` and `out_msr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_opclass | input | 4 | Decoded operation class code |
| in_insn | input | 32 | Raw instruction word |
| in_cia | input | 64 | Address of the presented instruction |
| in_msr | input | 64 | Current machine state register |
| in_illegal | input | 1 | Decoder marks the instruction illegal |
| in_br_taken | input | 1 | Instruction redirects to a branch target |
| in_br_target | input | 64 | Branch target address |
| out_valid | output | 1 | Result for the previous cycle's instruction |
| out_trap | output | 1 | Program interrupt raised |
| out_nia | output | 64 | Next instruction address |
| out_srr0_we | output | 1 | Write enable, first save/restore register |
| out_srr0 | output | 64 | Data for first save/restore register |
| out_srr1_we | output | 1 | Write enable, second save/restore register |
| out_srr1 | output | 64 | Data for second save/restore register |
| out_msr_we | output | 1 | Machine state update enable |
| out_msr | output | 64 | Updated machine state value |
| out_commit_wb | output | 1 | Instruction's own writebacks may proceed |

## Verification
The assertions assume that the decoder holds `in_illegal`, `in_opclass` and the branch inputs stable for the single cycle in which `in_valid` is high. They also assume that a value of the machine state register presented with an instruction already reflects every earlier commit, since the unit keeps no state of its own. The directed stimulus presents one instruction per task with `in_valid` high for exactly one cycle. It changes inputs only on the falling edge and drives class codes only within the eight defined values. It covers both settings of the problem-state bit and of instruction bit 20.

// File: rtl/ptrap_pkg.sv
// ptrap_pkg: shared constants and types for the program interrupt trap unit.
// Assumes LSB-numbered bit positions everywhere.
package ptrap_pkg;

    localparam int XLEN      = 64;
    localparam int OPC_W     = 4;
    localparam int INSN_W    = 32;

    // Operation class codes produced by the decoder.
    typedef enum logic [OPC_W-1:0] {
        OPC_ORDINARY = 4'd0,
        OPC_ATTN     = 4'd1,
        OPC_RD_MSR   = 4'd2,
        OPC_WR_MSR   = 4'd3,
        OPC_WR_MSR_D = 4'd4,
        OPC_RET_INT  = 4'd5,
        OPC_RD_SPR   = 4'd6,
        OPC_WR_SPR   = 4'd7
    } opclass_e;

    // One-hot trap cause, bit 0 privilege, bit 1 illegal.
    typedef struct packed {
        logic illegal;
        logic priv;
    } cause_t;

endpackage

// File: rtl/ptrap_priv_decode.sv
// ptrap_priv_decode: decides whether an operation class needs supervisor
// rights. Classes in ALWAYS_MASK are privileged unconditionally; classes in
// COND_MASK are privileged only when the register-number MSB bit is set.
// Assumes the class code is valid in the cycle it is presented.
module ptrap_priv_decode #(
    parameter int                    OPC_W       = 4,
    parameter logic [(1<<OPC_W)-1:0] ALWAYS_MASK = 'h3E,
    parameter logic [(1<<OPC_W)-1:0] COND_MASK   = 'hC0
) (
    input  logic [OPC_W-1:0] opclass_i,
    input  logic             regnum_msb_i,
    output logic             priv_o
);
    localparam int NCLS = 1 << OPC_W;

    logic [NCLS-1:0] class_hit;

    // One comparator per class code.
    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        assign class_hit[g] = (opclass_i == OPC_W'(g));
    end

    // Combine unconditional and register-number-qualified privilege.
    always_comb begin
        priv_o = (|(class_hit & ALWAYS_MASK)) |
                 ((|(class_hit & COND_MASK)) & regnum_msb_i);
    end
endmodule

// File: rtl/ptrap_arbiter.sv
// ptrap_arbiter: turns privilege, problem state and the illegal flag into a
// trap decision with a one-hot cause, and builds the updated machine state.
// A privilege violation outranks an illegal flag. Assumes bit positions are
// distinct and below XLEN.
module ptrap_arbiter
    import ptrap_pkg::*;
#(
    parameter int XLEN_P     = 64,
    parameter int PR_BIT     = 14,
    parameter int PRIV_CAUSE = 18,
    parameter int ILL_CAUSE  = 19
) (
    input  logic              priv_i,
    input  logic              illegal_i,
    input  logic [XLEN_P-1:0] msr_i,
    output logic              trap_o,
    output cause_t            cause_o,
    output logic [XLEN_P-1:0] msr_next_o
);
    logic              user_mode;
    logic [XLEN_P-1:0] cause_mask;

    // Problem-state bit of the current machine state.
    assign user_mode = msr_i[PR_BIT];

    // Prioritised cause selection.
    always_comb begin
        cause_o.priv    = priv_i & user_mode;
        cause_o.illegal = illegal_i & ~cause_o.priv;
        trap_o          = cause_o.priv | cause_o.illegal;
    end

    // Machine state with the selected cause bit raised.
    always_comb begin
        cause_mask = '0;
        cause_mask[PRIV_CAUSE] = cause_o.priv;
        cause_mask[ILL_CAUSE]  = cause_o.illegal;
        msr_next_o = msr_i | cause_mask;
    end
endmodule

// File: rtl/ptrap_nia_sel.sv
// ptrap_nia_sel: chooses the next fetch address: interrupt vector on a trap,
// branch target when taken, else the sequential address. Assumes fixed-size
// instructions of ILEN bytes.
module ptrap_nia_sel #(
    parameter int                 XLEN_P = 64,
    parameter logic [XLEN_P-1:0]  VECTOR = 64'h700,
    parameter int                 ILEN   = 4
) (
    input  logic              trap_i,
    input  logic [XLEN_P-1:0] cia_i,
    input  logic              br_taken_i,
    input  logic [XLEN_P-1:0] br_target_i,
    output logic [XLEN_P-1:0] nia_o
);
    logic [XLEN_P-1:0] seq_addr;

    // Sequential successor, wrapping at the top of the address space.
    assign seq_addr = cia_i + XLEN_P'(ILEN);

    // Trap redirect outranks branch, branch outranks sequential.
    always_comb begin
        if (trap_i)          nia_o = VECTOR;
        else if (br_taken_i) nia_o = br_target_i;
        else                 nia_o = seq_addr;
    end
endmodule

// File: rtl/ptrap_unit.sv
// ptrap_unit: program interrupt trap unit. Classifies each presented
// instruction, decides whether it traps, and registers the commit controls
// (next address, save/restore writes, machine state update, writeback
// permission) one cycle later. Assumes one instruction per valid cycle and
// a machine state input that is already current.
module ptrap_unit
    import ptrap_pkg::*;
#(
    parameter int                XLEN_P      = XLEN,
    parameter int                OPC_W_P     = OPC_W,
    parameter int                INSN_W_P    = INSN_W,
    parameter int                REGNUM_MSB  = 20,
    parameter int                PR_BIT      = 14,
    parameter int                PRIV_CAUSE  = 18,
    parameter int                ILL_CAUSE   = 19,
    parameter logic [XLEN_P-1:0] VECTOR      = 64'h700,
    parameter int                ILEN        = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OPC_W_P-1:0]  in_opclass,
    input  logic [INSN_W_P-1:0] in_insn,
    input  logic [XLEN_P-1:0]   in_cia,
    input  logic [XLEN_P-1:0]   in_msr,
    input  logic                in_illegal,
    input  logic                in_br_taken,
    input  logic [XLEN_P-1:0]   in_br_target,
    output logic                out_valid,
    output logic                out_trap,
    output logic [XLEN_P-1:0]   out_nia,
    output logic                out_srr0_we,
    output logic [XLEN_P-1:0]   out_srr0,
    output logic                out_srr1_we,
    output logic [XLEN_P-1:0]   out_srr1,
    output logic                out_msr_we,
    output logic [XLEN_P-1:0]   out_msr,
    output logic                out_commit_wb
);
    logic              is_priv;
    logic              trap_c;
    cause_t            cause_c;
    logic [XLEN_P-1:0] msr_next_c;
    logic [XLEN_P-1:0] nia_c;
    logic              unused_insn;

    // Only the register-number MSB of the instruction word is consulted.
    assign unused_insn = ^(in_insn & ~(INSN_W_P'(1) << REGNUM_MSB));

    ptrap_priv_decode #(
        .OPC_W      (OPC_W_P)
    ) u_priv (
        .opclass_i    (in_opclass),
        .regnum_msb_i (in_insn[REGNUM_MSB]),
        .priv_o       (is_priv)
    );

    ptrap_arbiter #(
        .XLEN_P     (XLEN_P),
        .PR_BIT     (PR_BIT),
        .PRIV_CAUSE (PRIV_CAUSE),
        .ILL_CAUSE  (ILL_CAUSE)
    ) u_arb (
        .priv_i     (is_priv),
        .illegal_i  (in_illegal),
        .msr_i      (in_msr),
        .trap_o     (trap_c),
        .cause_o    (cause_c),
        .msr_next_o (msr_next_c)
    );

    ptrap_nia_sel #(
        .XLEN_P (XLEN_P),
        .VECTOR (VECTOR),
        .ILEN   (ILEN)
    ) u_nia (
        .trap_i      (trap_c),
        .cia_i       (in_cia),
        .br_taken_i  (in_br_taken),
        .br_target_i (in_br_target),
        .nia_o       (nia_c)
    );

    // Strobes: asserted for one cycle per accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_trap      <= 1'b0;
            out_srr0_we   <= 1'b0;
            out_srr1_we   <= 1'b0;
            out_msr_we    <= 1'b0;
            out_commit_wb <= 1'b0;
        end else begin
            out_valid     <= in_valid;
            out_trap      <= in_valid & trap_c;
            out_srr0_we   <= in_valid & trap_c;
            out_srr1_we   <= in_valid & trap_c;
            out_msr_we    <= in_valid & (cause_c.priv | cause_c.illegal);
            out_commit_wb <= in_valid & ~trap_c;
        end
    end

    // Data: captured on accepted instructions, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_nia  <= '0;
            out_srr0 <= '0;
            out_srr1 <= '0;
            out_msr  <= '0;
        end else if (in_valid) begin
            out_nia  <= nia_c;
            out_srr0 <= in_cia;
            out_srr1 <= in_msr;
            out_msr  <= msr_next_c;
        end
    end
endmodule

// File: rtl/ptrap_checker.sv
// ptrap_checker: concurrent properties for ptrap_unit, attached by bind.
// Assumes inputs are stable within each valid cycle.
module ptrap_checker #(
    parameter int        PR_BIT     = 14,
    parameter int        PRIV_CAUSE = 18,
    parameter int        ILL_CAUSE  = 19,
    parameter logic [63:0] VECTOR   = 64'h700
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  in_opclass,
    input logic [63:0] in_cia,
    input logic [63:0] in_msr,
    input logic        in_illegal,
    input logic        in_br_taken,
    input logic        out_valid,
    input logic        out_trap,
    input logic [63:0] out_nia,
    input logic        out_srr0_we,
    input logic [63:0] out_srr0,
    input logic        out_srr1_we,
    input logic [63:0] out_srr1,
    input logic        out_msr_we,
    input logic [63:0] out_msr,
    input logic        out_commit_wb
);
    p_ordinary_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opclass == 4'd0 && !in_illegal) |=> !out_trap);

    p_super_no_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_illegal && !in_msr[PR_BIT]) |=> !out_trap);

    p_srr_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_illegal) |=> (out_srr0_we && out_srr1_we &&
            out_srr0 == $past(in_cia) && out_srr1 == $past(in_msr)));

    p_illegal_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_illegal && !in_msr[PR_BIT]) |=> (out_msr_we &&
            out_msr[ILL_CAUSE] && out_msr[PRIV_CAUSE] == $past(in_msr[PRIV_CAUSE])));

    p_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> out_nia == VECTOR);

    p_seq_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_illegal && !in_msr[PR_BIT] && !in_br_taken)
            |=> out_nia == $past(in_cia) + 64'd4);

    p_commit_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_trap != out_commit_wb));

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_trap && !out_commit_wb &&
            !out_srr0_we && !out_srr1_we && !out_msr_we));
endmodule

bind ptrap_unit ptrap_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_opclass    (in_opclass),
    .in_cia        (in_cia),
    .in_msr        (in_msr),
    .in_illegal    (in_illegal),
    .in_br_taken   (in_br_taken),
    .out_valid     (out_valid),
    .out_trap      (out_trap),
    .out_nia       (out_nia),
    .out_srr0_we   (out_srr0_we),
    .out_srr0      (out_srr0),
    .out_srr1_we   (out_srr1_we),
    .out_srr1      (out_srr1),
    .out_msr_we    (out_msr_we),
    .out_msr       (out_msr),
    .out_commit_wb (out_commit_wb)
);

// File: tb/ptrap_unit_test.sv
// ptrap_unit_test: directed bench, one task per scenario.
module ptrap_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_opclass = '0;
    logic [31:0] in_insn = '0;
    logic [63:0] in_cia = '0;
    logic [63:0] in_msr = '0;
    logic        in_illegal = 1'b0;
    logic        in_br_taken = 1'b0;
    logic [63:0] in_br_target = '0;
    logic        out_valid, out_trap, out_srr0_we, out_srr1_we, out_msr_we, out_commit_wb;
    logic [63:0] out_nia, out_srr0, out_srr1, out_msr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    ptrap_unit uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one instruction, then check all outputs against the model.
    task automatic apply(input logic [3:0] opc, input logic [31:0] insn,
                         input logic [63:0] cia, input logic [63:0] msr,
                         input logic ill, input logic brt, input logic [63:0] tgt);
        logic priv, ptrap, trap;
        logic [63:0] exp_msr, exp_nia;
        priv  = (opc >= 4'd1 && opc <= 4'd5) ||
                ((opc == 4'd6 || opc == 4'd7) && insn[20]);
        ptrap = priv && msr[14];
        trap  = ptrap || ill;
        exp_msr = msr;
        if (ptrap) exp_msr[18] = 1'b1;
        else if (ill) exp_msr[19] = 1'b1;
        exp_nia = trap ? 64'h700 : (brt ? tgt : cia + 64'd4);
        @(negedge clk);
        in_valid = 1'b1; in_opclass = opc; in_insn = insn; in_cia = cia;
        in_msr = msr; in_illegal = ill; in_br_taken = brt; in_br_target = tgt;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "out_valid", 64'(out_valid), 64'd1);
        chk(ill ? "R5" : "R3", "out_trap", 64'(out_trap), 64'(trap));
        chk(trap ? "R7" : "R8", "out_nia", out_nia, exp_nia);
        chk("R4", "srr write enables", 64'({out_srr0_we, out_srr1_we}), 64'({trap, trap}));
        if (trap) begin
            chk("R4", "out_srr0", out_srr0, cia);
            chk("R4", "out_srr1", out_srr1, msr);
            chk(ptrap && ill ? "R6" : "R5", "out_msr", out_msr, exp_msr);
        end
        chk("R5", "out_msr_we", 64'(out_msr_we), 64'(trap));
        chk("R9", "out_commit_wb", 64'(out_commit_wb), 64'(!trap));
    endtask

    localparam logic [63:0] USER = 64'h4000;   // bit 14 set
    localparam logic [63:0] SUPV = 64'h0;
    localparam logic [31:0] B20  = 32'h0010_0000;

    task automatic t_reset();
        chk("R11", "strobes after reset",
            64'({out_valid, out_trap, out_srr0_we, out_srr1_we, out_msr_we, out_commit_wb}), 64'd0);
        chk("R11", "out_nia after reset", out_nia, 64'd0);
        chk("R11", "out_msr after reset", out_msr | out_srr0 | out_srr1, 64'd0);
    endtask

    task automatic t_always_priv_r1();
        for (int c = 1; c <= 5; c++)
            apply(4'(c), 32'h0, 64'h1000 + 64'(c*4), USER | 64'h8000_0000_0000_0001, 1'b0, 1'b0, '0);
        apply(4'd0, 32'hFFFF_FFFF, 64'h2000, USER, 1'b0, 1'b0, '0);
    endtask

    task automatic t_spr_rule_r2();
        apply(4'd6, ~B20, 64'h3000, USER, 1'b0, 1'b0, '0);
        apply(4'd6, B20,  64'h3004, USER, 1'b0, 1'b0, '0);
        apply(4'd7, 32'h0, 64'h3008, USER, 1'b0, 1'b0, '0);
        apply(4'd7, B20,  64'h300C, USER, 1'b0, 1'b0, '0);
    endtask

    task automatic t_supervisor_r3();
        for (int c = 0; c <= 7; c++)
            apply(4'(c), B20, 64'h4000 + 64'(c*4), SUPV | 64'hFFFF_0000_0000_0000, 1'b0, 1'b0, '0);
    endtask

    task automatic t_illegal_r5();
        apply(4'd0, 32'h0, 64'h5000, SUPV | 64'h4_0000, 1'b1, 1'b0, '0);
        apply(4'd0, 32'h0, 64'h5004, USER, 1'b1, 1'b1, 64'h9999);
    endtask

    task automatic t_priority_r6();
        apply(4'd2, 32'h0, 64'h6000, USER, 1'b1, 1'b0, '0);
        apply(4'd7, B20,   64'h6004, USER | 64'h8_0000, 1'b1, 1'b0, '0);
    endtask

    task automatic t_branch_r8();
        apply(4'd0, 32'h0, 64'h7000, USER, 1'b0, 1'b1, 64'hDEAD_BEE0);
        apply(4'd1, 32'h0, 64'h7004, USER, 1'b0, 1'b1, 64'hDEAD_BEE0);   // R7 trap wins
        apply(4'd0, 32'h0, 64'hFFFF_FFFF_FFFF_FFFC, SUPV, 1'b0, 1'b0, '0); // wraps to 0
    endtask

    task automatic t_idle_r10();
        @(negedge clk);
        in_valid = 1'b0; in_illegal = 1'b1; in_opclass = 4'd1; in_msr = USER;
        @(negedge clk);
        chk("R10", "idle strobes",
            64'({out_valid, out_trap, out_srr0_we, out_srr1_we, out_msr_we, out_commit_wb}), 64'd0);
        in_illegal = 1'b0; in_opclass = 4'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_always_priv_r1();
        t_spr_rule_r2();
        t_supervisor_r3();
        t_illegal_r5();
        t_priority_r6();
        t_branch_r8();
        t_idle_r10();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule